// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is a reloadable up-counter for a small microcontroller. A control register picks one of three counting behaviours: counting ticks from one of two internal time bases, counting chosen edges of an external input, or measuring how long that input stays at a chosen level by counting time-base ticks between a start edge and a stop edge. When the counter is at its top value and receives one more increment, it reloads from a preload register and raises a one-cycle interrupt request. The request reaches the output only when an interrupt-enable bit is set.

Software reaches four byte-wide registers over a simple synchronous bus: control, preload, count and interrupt enable. Read data is registered and appears one clock after the address is presented. The external input is synchronised to the clock before its edges are detected. In width-measurement mode, the stop edge freezes the count and clears the run bit, so software can poll the run bit and then read the measured width.

Top module: `tick_event_counter`

## Requirements
- R1: After reset, the control register reads 0x00, the count reads 0x00 and `irq` is low. The register addresses are: control at 0, preload at 1, count at 2 (read only), interrupt enable at 3 (bit 0).
- R2: The control layout is: bits 7:6 select the mode, bit 5 selects the clock, bit 4 is run and bit 3 is edge select. Bits 2:0 always read as zero, whatever value is written to them.
- R3: Mode 00 never changes the count, even with run set and with ticks and pin edges present.
- R4: In mode 01 the count advances once per pin edge. Edge select 0 counts rising edges and edge select 1 counts falling edges. Edges of the other polarity and the tick inputs are ignored.
- R5: In mode 10 the count advances once per tick of the selected source. Clock select 0 selects `tick_sys4` and clock select 1 selects `tick_32k`. The unselected tick is ignored.
- R6: While run is 0 the count holds its value in every mode.
- R7: An increment at count 0xFF loads the count from the preload register. With interrupt enable set, it also produces exactly one `irq` pulse.
- R8: With interrupt enable clear, an overflow still reloads the count but `irq` stays low.
- R9: A preload write while run is 0 also loads the count. A preload write while run is 1 leaves the count unchanged.
- R10: In mode 11 with edge select 1, counting of selected-clock ticks starts on a rising pin edge and stops on the next falling edge. The stop edge clears run.
- R11: In mode 11 with edge select 0, counting starts on a falling edge and stops on the next rising edge. A stop-polarity edge seen before any start edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| event_pin | input | 1 | Asynchronous external event input |
| tick_sys4 | input | 1 | One-cycle tick at the system clock divided by four |
| tick_32k | input | 1 | One-cycle tick from the 32768 Hz time base |
| irq | output | 1 | One-cycle overflow interrupt request |

## Verification
The main counting path is driven with pin toggles, bursts on each tick input and mixtures of both. Because every mode sees all three stimuli, a wrong mode decode or a swapped source shows up as a count that moved when it should not have. In event mode, rising-only and falling-only counting are each run against the same alternating pin pattern, which separates a correct edge-select polarity from an inverted one. Overflow runs start from a preload just below the top value, with interrupts enabled and then disabled, so reload and interrupt gating are judged separately. Width runs place ticks before the start edge, between the edges and after the stop edge, so a measurement window that opens early or closes late changes the result.

// File: rtl/tec_pkg.sv
package tec_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_WIDTH = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  clk_sel;
    logic  run;
    logic  edge_sel;
  } ctrl_t;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_CTRL    = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT   = 2'd2;
  localparam logic [ADDR_W-1:0] A_IRQEN   = 2'd3;
endpackage

// File: rtl/tec_pin_edges.sv
module tec_pin_edges #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              level;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level  = sync_q[STAGES-1];
  assign rise_o = level & ~last_q;
  assign fall_o = ~level & last_q;

  // R4: one detected edge per cycle at most
  assert_edge_single_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_o, fall_o}));
  // R4: an edge pulse lasts one cycle
  assert_rise_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tec_regs.sv
module tec_regs
  import tec_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              run_clr_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  preload_o,
  output logic              irq_en_o,
  output logic              load_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o    <= '0;
      preload_o <= '0;
      irq_en_o  <= 1'b0;
    end else begin
      if (run_clr_i) ctrl_o.run <= 1'b0;
      if (wr_i) begin
        case (addr_i)
          A_CTRL:    ctrl_o    <= ctrl_t'(wdata_i[7:3]);
          A_PRELOAD: preload_o <= wdata_i[CNT_W-1:0];
          A_IRQEN:   irq_en_o  <= wdata_i[0];
          default:   ;
        endcase
      end
    end
  end

  assign load_o = wr_i && (addr_i == A_PRELOAD) && !ctrl_o.run;
endmodule

// File: rtl/tec_count_core.sv
module tec_count_core
  import tec_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tick_sys4_i,
  input  logic             tick_32k_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             stop_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic tick_sel, start_edge, stop_edge, measuring_q, inc;

  assign tick_sel   = ctrl_i.clk_sel ? tick_32k_i : tick_sys4_i;
  assign start_edge = ctrl_i.edge_sel ? rise_i : fall_i;
  assign stop_edge  = ctrl_i.edge_sel ? fall_i : rise_i;

  always_ff @(posedge clk) begin
    if (rst) measuring_q <= 1'b0;
    else if (!ctrl_i.run || ctrl_i.mode != MODE_WIDTH) measuring_q <= 1'b0;
    else if (stop_edge) measuring_q <= 1'b0;
    else if (start_edge) measuring_q <= 1'b1;
  end

  assign stop_o = ctrl_i.run && (ctrl_i.mode == MODE_WIDTH) && measuring_q && stop_edge;

  always_comb begin
    inc = 1'b0;
    if (ctrl_i.run) begin
      case (ctrl_i.mode)
        MODE_EVENT: inc = ctrl_i.edge_sel ? fall_i : rise_i;
        MODE_TIMER: inc = tick_sel;
        MODE_WIDTH: inc = measuring_q && tick_sel;
        default:    inc = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (load_i) cnt_o <= load_val_i;
      else if (inc) begin
        if (cnt_o == TOP) begin
          cnt_o <= preload_i;
          ovf_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end

  // R6 (and R3): no run or no mode, no load -> count frozen
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    ((!ctrl_i.run || ctrl_i.mode == MODE_OFF) && !load_i) |=> $stable(cnt_o));
  // R7: wrap loads the preload value
  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (inc && !load_i && cnt_o == TOP) |=> (cnt_o == $past(preload_i) && ovf_o));
endmodule

// File: rtl/tick_event_counter.sv
module tick_event_counter
  import tec_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        event_pin,
  input  logic        tick_sys4,
  input  logic        tick_32k,
  output logic        irq
);
  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] preload_w, cnt_w;
  logic             irq_en_w, load_w, rise_w, fall_w, ovf_w, stop_w;

  tec_pin_edges #(.STAGES(SYNC_STAGES)) edges_i (
    .clk(clk), .rst(rst), .pin_i(event_pin), .rise_o(rise_w), .fall_o(fall_w));

  tec_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .run_clr_i(stop_w), .ctrl_o(ctrl_w), .preload_o(preload_w),
    .irq_en_o(irq_en_w), .load_o(load_w));

  tec_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .ctrl_i(ctrl_w), .rise_i(rise_w), .fall_i(fall_w),
    .tick_sys4_i(tick_sys4), .tick_32k_i(tick_32k), .load_i(load_w),
    .load_val_i(bus_wdata[CNT_W-1:0]), .preload_i(preload_w),
    .cnt_o(cnt_w), .ovf_o(ovf_w), .stop_o(stop_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq <= ovf_w && irq_en_w;
      case (bus_addr)
        A_CTRL:    bus_rdata <= {ctrl_w, 3'b000};
        A_PRELOAD: bus_rdata <= 8'(preload_w);
        A_COUNT:   bus_rdata <= 8'(cnt_w);
        default:   bus_rdata <= {7'd0, irq_en_w};
      endcase
    end
  end

  // R2: control read-back keeps the low bits at zero
  assert_ctrl_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_CTRL) |=> (bus_rdata[2:0] == 3'b000));
  // R8: interrupt only when enabled
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en_w));
  // R7: interrupt follows an overflow
  assert_irq_after_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ovf_w));
  // R10: stop edge clears run unless software writes control that cycle
  assert_stop_clears_run_R10: assert property (@(posedge clk) disable iff (rst)
    (stop_w && !(bus_wr && bus_addr == A_CTRL)) |=> !ctrl_w.run);
endmodule

// File: tb/tick_event_counter_tb_top.sv
module tick_event_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       event_pin = 1'b0;
  logic       tick_sys4 = 1'b0;
  logic       tick_32k = 1'b0;
  logic       irq;

  always #2.5 clk = ~clk;

  tick_event_counter dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .event_pin(event_pin),
    .tick_sys4(tick_sys4), .tick_32k(tick_32k), .irq(irq));

  typedef struct {
    int        due;
    logic [7:0] exp;
    string     tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (irq === 1'b1) irq_seen++;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.due = cyc + 1; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    event_pin = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic ticks(input bit use32k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use32k) tick_32k = 1'b1; else tick_sys4 = 1'b1;
      @(negedge clk);
      tick_32k = 1'b0; tick_sys4 = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_irq(input int e, input string tag);
    checks++;
    if (irq_seen != e) begin
      errors++;
      $display("FAIL %s irq pulses actual=%0d expected=%0d", tag, irq_seen, e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_reg(2'd0, 8'h00, "R1 ctrl");
    expect_reg(2'd2, 8'h00, "R1 count");
    check_irq(0, "R1");
    // R2 low bits
    wr(2'd0, 8'hFF);
    expect_reg(2'd0, 8'hF8, "R2 ctrl low bits");
    wr(2'd0, 8'h00);
    // R9 load while stopped, then R3 mode off
    wr(2'd1, 8'h10);
    expect_reg(2'd2, 8'h10, "R9 load idle");
    wr(2'd0, 8'h10);
    ticks(0, 3); ticks(1, 3); set_pin(1); set_pin(0);
    expect_reg(2'd2, 8'h10, "R3 mode off");
    // R4 event rising
    wr(2'd0, 8'h50);
    set_pin(1); set_pin(0); set_pin(1); set_pin(0); ticks(1, 2);
    expect_reg(2'd2, 8'h12, "R4 rising");
    // R4 event falling
    wr(2'd0, 8'h58);
    set_pin(1); set_pin(0); set_pin(1); set_pin(0);
    expect_reg(2'd2, 8'h14, "R4 falling");
    // R6 stopped
    wr(2'd0, 8'h40);
    set_pin(1); set_pin(0);
    expect_reg(2'd2, 8'h14, "R6 hold");
    // R9 preload while running
    wr(2'd0, 8'h50);
    wr(2'd1, 8'h80);
    expect_reg(2'd2, 8'h14, "R9 no load running");
    wr(2'd0, 8'h40);
    wr(2'd1, 8'hFD);
    expect_reg(2'd2, 8'hFD, "R9 load stopped");
    // R5 timer
    wr(2'd0, 8'h90);
    ticks(0, 2); ticks(1, 3);
    expect_reg(2'd2, 8'hFF, "R5 sys4 source");
    wr(2'd0, 8'hB0);
    ticks(0, 1);
    expect_reg(2'd2, 8'hFF, "R5 32k selected");
    // R7 overflow with interrupt
    wr(2'd3, 8'h01);
    ticks(1, 1);
    expect_reg(2'd2, 8'hFD, "R7 reload");
    check_irq(1, "R7 first");
    ticks(1, 3);
    expect_reg(2'd2, 8'hFD, "R7 second reload");
    check_irq(2, "R7 second");
    // R8 interrupt disabled
    wr(2'd3, 8'h00);
    ticks(1, 3);
    expect_reg(2'd2, 8'hFD, "R8 reload");
    check_irq(2, "R8 masked");
    // R10 width, rising start
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hF8);
    ticks(1, 2);
    set_pin(1);
    ticks(1, 5);
    set_pin(0);
    ticks(1, 2);
    expect_reg(2'd2, 8'h05, "R10 width");
    expect_reg(2'd0, 8'hE8, "R10 run cleared");
    // R11 width, falling start
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hF0);
    set_pin(1);
    ticks(1, 2);
    set_pin(0);
    ticks(1, 4);
    set_pin(1);
    ticks(1, 2);
    expect_reg(2'd2, 8'h04, "R11 width");
    expect_reg(2'd0, 8'hE0, "R11 run cleared");
    check_irq(2, "R11 no irq");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule